// File: doc/BRIEF.md
# Cache Lockdown Command Controller

This block decodes writes and reads aimed at the cache-lockdown register space of a coprocessor-style control interface. It drives line locking for a small instruction cache and a small data cache. Each access presents a valid strobe, a write/read flag, a 4-bit CRm selector, a 3-bit opcode_2 selector and a 32-bit data word. The two caches lock in different ways:

- The instruction cache locks one explicit line. The controller raises a fetch-and-lock request that carries the line's virtual address and holds it until the cache acknowledges.
- The data cache has a sticky lock-mode bit. While that bit is set, every fill the data cache completes is tagged as locked.

Either cache can also be told to unlock everything with a one-cycle pulse. Commands aimed at a disabled cache are dropped. Reads of bits that carry no defined value return zero, so results are deterministic. The cache arrays, replacement logic and refill path are not part of the block. They appear only as request, acknowledge and fill ports.

Top module: `cache_lock_ctrl`

## Requirements
- R1: After reset, the following outputs are all 0: lock mode, `icLockReq`, `busy`, both unlock pulses and `rdData`.
- R2: A write with CRm=0001 and opcode_2=000, while `icEnable`=1 and `busy`=0, raises `icLockReq` and `busy` on the next clock edge. The same edge loads `icLockAddr` with the full data word.
- R3: While `icLockReq` is high and `icLockAck` is low, the request stays high and `icLockAddr` holds its value. A clock edge that samples `icLockAck` high with the request raised lowers the request and `busy` on that edge.
- R4: A fetch-and-lock write that arrives while `busy`=1 is not taken, and `icLockAddr` keeps the pending address. If the write is still presented once `busy` has fallen, it is taken then.
- R5: A write with CRm=0001 and opcode_2=001, while `icEnable`=1, produces a one-cycle `icUnlockAll` pulse after the next clock edge. The data word has no effect.
- R6: A write with CRm=0010 and opcode_2=001, while `dcEnable`=1, produces a one-cycle `dcUnlockAll` pulse after the next clock edge. The data word has no effect.
- R7: A write with CRm=0010 and opcode_2=000 loads lock mode from data bit 0, and data bits 31:1 are discarded. A read of the same encoding returns {31'b0, lock mode} on `rdData` after the next edge. `rdData` holds that value until the next read.
- R8: `dcFillLocked` is high exactly when `dcFillValid` is high and lock mode is currently 1.
- R9: Fetch-and-lock and instruction-cache unlock are dropped when `icEnable`=0. Data-cache unlock is dropped when `dcEnable`=0. A dropped command produces no request and no pulse.
- R10: A read of any encoding other than CRm=0010/opcode_2=000 returns 0. A write to an undefined encoding changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Register access strobe |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdCrm | input | 4 | CRm selector |
| cmdOp2 | input | 3 | opcode_2 selector |
| cmdData | input | 32 | Write data / line address |
| rdData | output | 32 | Read result, registered |
| busy | output | 1 | Fetch-and-lock request pending |
| icEnable | input | 1 | Instruction cache enabled |
| dcEnable | input | 1 | Data cache enabled |
| icLockReq | output | 1 | Fetch-and-lock request to instruction cache |
| icLockAddr | output | 32 | Address of the line to lock |
| icLockAck | input | 1 | Instruction cache accepts the request |
| icUnlockAll | output | 1 | Unlock-all pulse, instruction cache |
| dcUnlockAll | output | 1 | Unlock-all pulse, data cache |
| dcFillValid | input | 1 | Data cache completes a fill |
| dcFillLocked | output | 1 | The current fill is to be locked |

## Verification
The bench targets several corner cases, each tied to the fault it would expose:

- A second fetch-and-lock issued while one is still pending. A design that overwrites the address or re-raises the request would hand the cache a line it never acknowledged.
- Lock-mode writes with junk in bits 31:1, followed by reads. A design that stores the wide word would return nonzero upper bits.
- Commands aimed at disabled caches, and reads of write-only encodings. Here a careless decoder would emit stray pulses or leak data.
- Fills that land on the same edge as a lock-mode change. These show whether tagging uses the current mode rather than the incoming one.

// File: rtl/cache_lock_pkg.sv
package cache_lock_pkg;
  localparam int CRM_W = 4;
  localparam int OP2_W = 3;

  localparam logic [CRM_W-1:0] CRM_ICACHE  = 4'b0001;
  localparam logic [CRM_W-1:0] CRM_DCACHE  = 4'b0010;
  localparam logic [OP2_W-1:0] OP2_PRIMARY = 3'b000;
  localparam logic [OP2_W-1:0] OP2_UNLOCK  = 3'b001;

  typedef struct packed {
    logic fetchLock;
    logic icUnlock;
    logic dcUnlock;
    logic modeWrite;
    logic modeRead;
    logic zeroRead;
  } lockStrobes_t;
endpackage

// File: rtl/cache_lock_decode.sv
module cache_lock_decode
  import cache_lock_pkg::*;
(
  input  logic             cmdValid,
  input  logic             cmdWrite,
  input  logic [CRM_W-1:0] cmdCrm,
  input  logic [OP2_W-1:0] cmdOp2,
  input  logic             icEnable,
  input  logic             dcEnable,
  input  logic             pending,
  output lockStrobes_t     strobes
);
  logic hitIcLine, hitIcAll, hitDcMode, hitDcAll;

  always_comb begin
    hitIcLine = (cmdCrm == CRM_ICACHE) && (cmdOp2 == OP2_PRIMARY);
    hitIcAll  = (cmdCrm == CRM_ICACHE) && (cmdOp2 == OP2_UNLOCK);
    hitDcMode = (cmdCrm == CRM_DCACHE) && (cmdOp2 == OP2_PRIMARY);
    hitDcAll  = (cmdCrm == CRM_DCACHE) && (cmdOp2 == OP2_UNLOCK);

    strobes.fetchLock = cmdValid && cmdWrite && hitIcLine && icEnable && !pending;
    strobes.icUnlock  = cmdValid && cmdWrite && hitIcAll && icEnable;
    strobes.dcUnlock  = cmdValid && cmdWrite && hitDcAll && dcEnable;
    strobes.modeWrite = cmdValid && cmdWrite && hitDcMode;
    strobes.modeRead  = cmdValid && !cmdWrite && hitDcMode;
    strobes.zeroRead  = cmdValid && !cmdWrite && !hitDcMode;
  end
endmodule

// File: rtl/cache_lock_datapath.sv
module cache_lock_datapath
  import cache_lock_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  lockStrobes_t      strobes,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              icLockAck,
  input  logic              dcFillValid,
  output logic              pending,
  output logic [DATA_W-1:0] icLockAddr,
  output logic              icUnlockAll,
  output logic              dcUnlockAll,
  output logic [DATA_W-1:0] rdData,
  output logic              dcFillLocked
);
  localparam int PAD_W = DATA_W - 1;

  logic lockMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending     <= 1'b0;
      icLockAddr  <= '0;
      icUnlockAll <= 1'b0;
      dcUnlockAll <= 1'b0;
      lockMode    <= 1'b0;
      rdData      <= '0;
    end else begin
      icUnlockAll <= strobes.icUnlock;
      dcUnlockAll <= strobes.dcUnlock;
      if (strobes.fetchLock) begin
        pending    <= 1'b1;
        icLockAddr <= cmdData;
      end else if (pending && icLockAck) begin
        pending <= 1'b0;
      end
      if (strobes.modeWrite) lockMode <= cmdData[0];
      if (strobes.modeRead) rdData <= {{PAD_W{1'b0}}, lockMode};
      else if (strobes.zeroRead) rdData <= '0;
    end
  end

  assign dcFillLocked = dcFillValid && lockMode;
endmodule

// File: rtl/cache_lock_ctrl.sv
module cache_lock_ctrl
  import cache_lock_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic [CRM_W-1:0]  cmdCrm,
  input  logic [OP2_W-1:0]  cmdOp2,
  input  logic [DATA_W-1:0] cmdData,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  input  logic              icEnable,
  input  logic              dcEnable,
  output logic              icLockReq,
  output logic [DATA_W-1:0] icLockAddr,
  input  logic              icLockAck,
  output logic              icUnlockAll,
  output logic              dcUnlockAll,
  input  logic              dcFillValid,
  output logic              dcFillLocked
);
  lockStrobes_t strobes;
  logic         pending;

  cache_lock_decode u_decode (
    .cmdValid (cmdValid),
    .cmdWrite (cmdWrite),
    .cmdCrm   (cmdCrm),
    .cmdOp2   (cmdOp2),
    .icEnable (icEnable),
    .dcEnable (dcEnable),
    .pending  (pending),
    .strobes  (strobes)
  );

  cache_lock_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .cmdData      (cmdData),
    .icLockAck    (icLockAck),
    .dcFillValid  (dcFillValid),
    .pending      (pending),
    .icLockAddr   (icLockAddr),
    .icUnlockAll  (icUnlockAll),
    .dcUnlockAll  (dcUnlockAll),
    .rdData       (rdData),
    .dcFillLocked (dcFillLocked)
  );

  assign busy      = pending;
  assign icLockReq = pending;
endmodule

// File: rtl/cache_lock_ctrl_checker.sv
module cache_lock_ctrl_checker
  import cache_lock_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdWrite,
  input logic [CRM_W-1:0]  cmdCrm,
  input logic [OP2_W-1:0]  cmdOp2,
  input logic [DATA_W-1:0] rdData,
  input logic              icEnable,
  input logic              dcEnable,
  input logic              icLockReq,
  input logic [DATA_W-1:0] icLockAddr,
  input logic              icLockAck,
  input logic              icUnlockAll,
  input logic              dcUnlockAll,
  input logic              dcFillValid,
  input logic              dcFillLocked
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    icLockReq && !icLockAck |=> icLockReq && $stable(icLockAddr)); // R3

  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    icLockReq && icLockAck |=> !icLockReq); // R3

  AST_REQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(icLockReq) |-> $past(cmdValid && cmdWrite && cmdCrm == CRM_ICACHE
                               && cmdOp2 == OP2_PRIMARY && icEnable)); // R2

  AST_IC_UNLOCK_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    icUnlockAll |-> $past(cmdValid && cmdWrite && cmdCrm == CRM_ICACHE
                          && cmdOp2 == OP2_UNLOCK && icEnable)); // R5

  AST_DC_UNLOCK_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    dcUnlockAll |-> $past(cmdValid && cmdWrite && cmdCrm == CRM_DCACHE
                          && cmdOp2 == OP2_UNLOCK && dcEnable)); // R6

  AST_FILL_TAG: assert property (@(posedge clk) disable iff (!rstN)
    dcFillLocked |-> dcFillValid); // R8

  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:1] == '0); // R7
endmodule

bind cache_lock_ctrl cache_lock_ctrl_checker #(.DATA_W(DATA_W)) u_checker (.*);

// File: tb/cache_lock_ctrl_tb.sv
module cache_lock_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdWrite = 1'b0;
  logic [3:0]  cmdCrm = '0;
  logic [2:0]  cmdOp2 = '0;
  logic [31:0] cmdData = '0;
  logic [31:0] rdData;
  logic        busy;
  logic        icEnable = 1'b1, dcEnable = 1'b1;
  logic        icLockReq;
  logic [31:0] icLockAddr;
  logic        icLockAck = 1'b0;
  logic        icUnlockAll, dcUnlockAll;
  logic        dcFillValid = 1'b0;
  logic        dcFillLocked;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          expPend = 0, expMode = 0, expIcUnl = 0, expDcUnl = 0;
  logic [31:0] expAddr = '0, expRd = '0;

  always #4 clk = ~clk;

  cache_lock_ctrl u_dut (.*);

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit isEnc(input logic [3:0] c, input logic [2:0] o,
                               input logic [3:0] ec, input logic [2:0] eo);
    return c == ec && o == eo;
  endfunction

  task automatic step(input bit v, input bit w, input logic [3:0] c, input logic [2:0] o,
                      input logic [31:0] d, input bit ack, input bit fill,
                      input bit icEn, input bit dcEn);
    bit take;
    @(negedge clk);
    cmdValid = v; cmdWrite = w; cmdCrm = c; cmdOp2 = o; cmdData = d;
    icLockAck = ack; dcFillValid = fill; icEnable = icEn; dcEnable = dcEn;
    #1;
    check({31'b0, dcFillLocked}, {31'b0, fill & expMode}, "R8");
    take     = v && w && isEnc(c, o, 4'd1, 3'd0) && icEn && !expPend;
    expIcUnl = v && w && isEnc(c, o, 4'd1, 3'd1) && icEn;
    expDcUnl = v && w && isEnc(c, o, 4'd2, 3'd1) && dcEn;
    if (v && !w) expRd = isEnc(c, o, 4'd2, 3'd0) ? {31'b0, expMode} : 32'h0;
    if (take) begin expPend = 1; expAddr = d; end
    else if (expPend && ack) expPend = 0;
    if (v && w && isEnc(c, o, 4'd2, 3'd0)) expMode = d[0];
    @(posedge clk);
    #1;
    check({31'b0, icLockReq}, {31'b0, expPend}, "R2");
    check({31'b0, busy}, {31'b0, expPend}, "R4");
    if (expPend) check(icLockAddr, expAddr, "R3");
    check({31'b0, icUnlockAll}, {31'b0, expIcUnl}, "R5");
    check({31'b0, dcUnlockAll}, {31'b0, expDcUnl}, "R6");
    check(rdData, expRd, "R7");
  endtask

  task automatic idle();
    step(0, 0, 4'd0, 3'd0, 32'h0, 0, 0, 1, 1);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check({31'b0, icLockReq}, 32'h0, "R1");
    check({31'b0, busy}, 32'h0, "R1");
    check({30'b0, icUnlockAll, dcUnlockAll}, 32'h0, "R1");
    check(rdData, 32'h0, "R1");
    @(negedge clk);
    rstN = 1'b1;
    step(1, 0, 4'd2, 3'd0, 32'h0, 0, 1, 1, 1);  // R1 mode reads 0, fill untagged

    // R2/R3/R4 fetch-and-lock, stall, ack
    step(1, 1, 4'd1, 3'd0, 32'hCAFE_0040, 0, 0, 1, 1);
    step(1, 1, 4'd1, 3'd0, 32'hDEAD_0080, 0, 0, 1, 1);  // R4 stalled
    check(icLockAddr, 32'hCAFE_0040, "R4");
    step(0, 0, 4'd0, 3'd0, 32'h0, 0, 0, 1, 1);
    step(0, 0, 4'd0, 3'd0, 32'h0, 1, 0, 1, 1);           // R3 ack
    check({31'b0, icLockReq}, 32'h0, "R3");
    step(1, 1, 4'd1, 3'd0, 32'hDEAD_0080, 0, 0, 1, 1);  // R4 retry taken
    check(icLockAddr, 32'hDEAD_0080, "R4");
    step(0, 0, 4'd0, 3'd0, 32'h0, 1, 0, 1, 1);

    // R5/R6 unlock pulses, back to back
    step(1, 1, 4'd1, 3'd1, 32'hFFFF_FFFF, 0, 0, 1, 1);
    step(1, 1, 4'd2, 3'd1, 32'h1234_5678, 0, 0, 1, 1);
    idle();

    // R7 mode write with junk upper bits, fill tagging R8
    step(1, 1, 4'd2, 3'd0, 32'hFFFF_FFFF, 0, 1, 1, 1);  // fill same edge: old mode 0
    step(1, 0, 4'd2, 3'd0, 32'h0, 0, 1, 1, 1);          // fill tagged
    check(rdData, 32'h1, "R7");
    step(1, 1, 4'd2, 3'd0, 32'hFFFF_FFFE, 0, 1, 1, 1);
    step(1, 0, 4'd2, 3'd0, 32'h0, 0, 1, 1, 1);
    check(rdData, 32'h0, "R7");
    step(1, 1, 4'd2, 3'd0, 32'h1, 0, 0, 1, 1);

    // R9 disabled caches
    step(1, 1, 4'd1, 3'd0, 32'h0000_1000, 0, 0, 0, 1);
    check({31'b0, icLockReq}, 32'h0, "R9");
    step(1, 1, 4'd1, 3'd1, 32'h0, 0, 0, 0, 1);
    check({31'b0, icUnlockAll}, 32'h0, "R9");
    step(1, 1, 4'd2, 3'd1, 32'h0, 0, 0, 1, 0);
    check({31'b0, dcUnlockAll}, 32'h0, "R9");

    // R10 undefined reads and writes
    step(1, 0, 4'd2, 3'd0, 32'h0, 0, 0, 1, 1);
    step(1, 0, 4'd1, 3'd0, 32'h0, 0, 0, 1, 1);
    check(rdData, 32'h0, "R10");
    step(1, 1, 4'd3, 3'd0, 32'hFFFF_FFFF, 0, 0, 1, 1);
    step(1, 1, 4'd2, 3'd2, 32'h0, 0, 0, 1, 1);
    check({29'b0, icLockReq, icUnlockAll, dcUnlockAll}, 32'h0, "R10");
    step(1, 0, 4'd2, 3'd0, 32'h0, 0, 0, 1, 1);
    check(rdData, 32'h1, "R10");

    // constrained random
    for (int i = 0; i < 2000; i++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1), 4'($urandom_range(0, 3)),
           3'($urandom_range(0, 2)), $urandom, $urandom_range(0, 2) == 0,
           $urandom_range(0, 1), $urandom_range(0, 5) != 0, $urandom_range(0, 5) != 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule